// File: doc/BRIEF.md
# Sixteen-Channel Pulse-Width Modulator with Staged Updates

This block produces sixteen pulse-width modulated outputs from one shared timebase. A prescaler divides the input clock into step ticks. An 8-bit step counter advances on each tick and wraps after a programmable number of steps. Each channel has a rise position and a fall position within that count, and its own enable bit. When the rise position is above the fall position, the output is high across the wrap instead, which inverts the polarity of the pulse.

Software reaches the block through a plain byte-wide register port. Writes are synchronous and reads are combinational. The prescale value and the period value are always staged. Each channel's edge values are staged only when that channel's bit is set in a staging mask; otherwise they apply on the next clock. Staged values are copied into the working set only at a period boundary, and only after software has written 1 to the update-request register. Because the copy happens only at a boundary, a change can never cut a period short or produce a runt pulse.

Top module: `pwm_multi`

## Requirements
- R1: After reset all outputs are 0, the prescale reads 0x00, the period reads 0xFF, and the enable, mask, edge and update-request registers read 0. The register map is: prescale 0x00, period 0x01, update request 0x02 (bit 0), enables 0x08/0x09, staging mask 0x0C/0x0D, and edges at 0x20 + 2·channel (rise) and 0x21 + 2·channel (fall).
- R2: One output period lasts (period + 1) × (prescale + 1) clock cycles. The prescaler counts 0..prescale, and the step counter counts 0..period, advancing once per prescaler wrap.
- R3: Channel c is enabled by bit c mod 8 of the register at 0x08 (channels 0–7) or 0x09 (channels 8–15). A disabled channel drives 0.
- R4: When rise ≤ fall, an enabled output is high exactly while rise ≤ step < fall. When rise equals fall, the output stays low.
- R5: When rise > fall, an enabled output is high while step ≥ rise or step < fall, which gives inverted polarity.
- R6: Rise 0 with fall = period + 1 gives a constant high output. With the period at 0xFF, no setting gives constant high: rise 0 with fall 0xFF is low for one step in every period.
- R7: Writes to prescale, period and the edges of a channel whose mask bit is 1 change no output until a transfer takes place.
- R8: Writing 1 to bit 0 of 0x02 sets a pending flag, which reads back on bit 0. The transfer happens on the clock edge where the step counter wraps from period to 0 on a tick. The flag then clears.
- R9: An edge write to a channel whose mask bit is 0 takes effect on the next clock.
- R10: A staged edge write in the same cycle as a transfer is not carried by that transfer. An update request written in the same cycle as a transfer leaves the flag set for the following boundary.
- R11: The prescale, period and edge registers read back the last value written, even before any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr |
| pwmOut | output | 16 | Channel outputs |

## Verification
Two things can land on the same clock edge: a register write, and the shadow-to-working transfer at a period boundary. The bench runs its own model of the counters alongside the design, so it can tell which negative edge comes just before a wrap. At that moment it drives a staged edge write, and in a second pass it drives a fresh update request. The first case is judged by the pulse width seen in the next period, which must still reflect the old staged value. The second is judged by the request flag read back after the boundary, which must still be set.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int NUM_CH = 16;
  parameter int ADDR_W = 6;
  parameter int DATA_W = 8;
  localparam int SEL_W = $clog2(NUM_CH);
  localparam int EN_BYTES = NUM_CH / 8;

  localparam int ADDR_PRE  = 0;
  localparam int ADDR_PER  = 1;
  localparam int ADDR_SYNC = 2;
  localparam int ADDR_EN   = 8;
  localparam int ADDR_MASK = 12;

  typedef struct packed {
    logic              wrPre;
    logic              wrPer;
    logic              wrEn;
    logic              wrMask;
    logic              wrEdge;
    logic              edgeFall;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
    logic              xfer;
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int CH = NUM_CH,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [7:0]    busWrData,
  input  logic          periodEnd,
  output pwm_strobe_t   strobe,
  output logic          syncPending
);
  localparam int EB = CH / 8;

  logic syncWr;
  logic inEn;
  logic inMask;
  int   addrInt;

  assign addrInt = int'(busAddr);
  assign syncWr  = busWrEn && (addrInt == ADDR_SYNC) && busWrData[0];
  assign inEn    = (addrInt >= ADDR_EN)   && (addrInt < ADDR_EN + EB);
  assign inMask  = (addrInt >= ADDR_MASK) && (addrInt < ADDR_MASK + EB);

  always_comb begin
    strobe          = '0;
    strobe.data     = busWrData;
    strobe.wrPre    = busWrEn && (addrInt == ADDR_PRE);
    strobe.wrPer    = busWrEn && (addrInt == ADDR_PER);
    strobe.wrEn     = busWrEn && inEn;
    strobe.wrMask   = busWrEn && inMask;
    strobe.wrEdge   = busWrEn && busAddr[AW-1];
    strobe.edgeFall = busAddr[0];
    if (busAddr[AW-1])
      strobe.sel = busAddr[SEL_W:1];
    else if (inEn)
      strobe.sel = SEL_W'(addrInt - ADDR_EN);
    else
      strobe.sel = SEL_W'(addrInt - ADDR_MASK);
    strobe.xfer = syncPending && periodEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      syncPending <= 1'b0;
    else if (syncWr)
      syncPending <= 1'b1;
    else if (periodEnd)
      syncPending <= 1'b0;
  end

  p_pending_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (syncPending && periodEnd && !syncWr) |=> !syncPending);
  p_pending_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (syncPending && !periodEnd) |=> syncPending);
  p_rearm_r10: assert property (@(posedge clk) disable iff (!rstN)
    syncWr |=> syncPending);
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CH = NUM_CH,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  pwm_strobe_t   strobe,
  input  logic          syncPending,
  input  logic [AW-1:0] busAddr,
  output logic [7:0]    busRdData,
  output logic          periodEnd,
  output logic [CH-1:0] pwmOut
);
  localparam int EB = CH / 8;

  logic [7:0]    shPre, shPer, actPre, actPer;
  logic [7:0]    preCnt, stepCnt;
  logic [CH-1:0] enableVec, maskVec;
  logic [7:0]    shRise [CH];
  logic [7:0]    shFall [CH];
  logic [7:0]    actRise [CH];
  logic [7:0]    actFall [CH];
  logic          tick;

  assign tick      = (preCnt == actPre);
  assign periodEnd = tick && (stepCnt == actPer);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      stepCnt <= '0;
    end else begin
      preCnt <= tick ? 8'd0 : preCnt + 8'd1;
      if (tick) stepCnt <= (stepCnt == actPer) ? 8'd0 : stepCnt + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPre     <= 8'h00;
      shPer     <= 8'hFF;
      actPre    <= 8'h00;
      actPer    <= 8'hFF;
      enableVec <= '0;
      maskVec   <= '0;
    end else begin
      if (strobe.wrPre) shPre <= strobe.data;
      if (strobe.wrPer) shPer <= strobe.data;
      if (strobe.xfer) begin
        actPre <= shPre;
        actPer <= shPer;
      end
      for (int b = 0; b < EB; b++) begin
        if (strobe.wrEn && (int'(strobe.sel) == b))   enableVec[b*8 +: 8] <= strobe.data;
        if (strobe.wrMask && (int'(strobe.sel) == b)) maskVec[b*8 +: 8]   <= strobe.data;
      end
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic hit;
    logic inWin;

    assign hit = strobe.wrEdge && (int'(strobe.sel) == i);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shRise[i]  <= '0;
        shFall[i]  <= '0;
        actRise[i] <= '0;
        actFall[i] <= '0;
      end else begin
        if (hit && !strobe.edgeFall) shRise[i] <= strobe.data;
        if (hit &&  strobe.edgeFall) shFall[i] <= strobe.data;
        if (maskVec[i]) begin
          if (strobe.xfer) begin
            actRise[i] <= shRise[i];
            actFall[i] <= shFall[i];
          end
        end else begin
          if (hit && !strobe.edgeFall) actRise[i] <= strobe.data;
          if (hit &&  strobe.edgeFall) actFall[i] <= strobe.data;
        end
      end
    end

    assign inWin = (actRise[i] <= actFall[i])
                 ? (stepCnt >= actRise[i] && stepCnt < actFall[i])
                 : (stepCnt >= actRise[i] || stepCnt < actFall[i]);
    assign pwmOut[i] = enableVec[i] && inWin;

    p_staged_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (maskVec[i] && !strobe.xfer) |=> $stable(actRise[i]) && $stable(actFall[i]));
  end

  always_comb begin
    int a;
    a = int'(busAddr);
    busRdData = '0;
    if (busAddr[AW-1])
      busRdData = busAddr[0] ? shFall[busAddr[SEL_W:1]] : shRise[busAddr[SEL_W:1]];
    else if (a == ADDR_PRE)  busRdData = shPre;
    else if (a == ADDR_PER)  busRdData = shPer;
    else if (a == ADDR_SYNC) busRdData = {7'd0, syncPending};
    else if (a >= ADDR_EN && a < ADDR_EN + EB)     busRdData = enableVec[(a - ADDR_EN)*8 +: 8];
    else if (a >= ADDR_MASK && a < ADDR_MASK + EB) busRdData = maskVec[(a - ADDR_MASK)*8 +: 8];
  end

  p_step_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= actPer);
  p_pre_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= actPre);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (stepCnt == 8'd0) && (preCnt == 8'd0));
  p_xfer_boundary_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xfer |-> (tick && stepCnt == actPer));
  p_period_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.xfer |=> $stable(actPer) && $stable(actPre));
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int CH = NUM_CH,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [7:0]    busWrData,
  output logic [7:0]    busRdData,
  output logic [CH-1:0] pwmOut
);
  pwm_strobe_t strobe;
  logic        syncPending;
  logic        periodEnd;

  pwm_ctrl #(.CH(CH), .AW(AW)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .periodEnd(periodEnd), .strobe(strobe),
    .syncPending(syncPending)
  );

  pwm_datapath #(.CH(CH), .AW(AW)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .syncPending(syncPending),
    .busAddr(busAddr), .busRdData(busRdData), .periodEnd(periodEnd),
    .pwmOut(pwmOut)
  );
endmodule

// File: tb/test_pwm_multi.sv
module test_pwm_multi;
  logic        clk = 0;
  logic        rstN = 0;
  logic [5:0]  busAddr = 0;
  logic        busWrEn = 0;
  logic [7:0]  busWrData = 0;
  logic [7:0]  busRdData;
  logic [15:0] pwmOut;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference state
  int mPre, mPer, sPre, sPer, mPc, mSc, mPend, mEn, mMask;
  int sRise[16], sFall[16], aRise[16], aFall[16];

  always #4 clk = ~clk;

  pwm_multi i_pwm_multi (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut));

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre = 0; mPer = 255; sPre = 0; sPer = 255; mPc = 0; mSc = 0;
      mPend = 0; mEn = 0; mMask = 0;
      for (int i = 0; i < 16; i++) begin sRise[i] = 0; sFall[i] = 0; aRise[i] = 0; aFall[i] = 0; end
    end else begin
      int a, oldMask;
      bit tk, wrapNow, xf;
      a = int'(busAddr);
      oldMask = mMask;
      tk = (mPc == mPre);
      wrapNow = tk && (mSc == mPer);
      xf = (mPend != 0) && wrapNow;
      mPc = tk ? 0 : mPc + 1;
      if (tk) mSc = (mSc == mPer) ? 0 : mSc + 1;
      if (xf) begin
        mPre = sPre; mPer = sPer;
        for (int i = 0; i < 16; i++)
          if (oldMask[i]) begin aRise[i] = sRise[i]; aFall[i] = sFall[i]; end
      end
      if (busWrEn && a == 2 && busWrData[0]) mPend = 1;
      else if (wrapNow) mPend = 0;
      if (busWrEn) begin
        if (a == 0) sPre = busWrData;
        if (a == 1) sPer = busWrData;
        if (a == 8) mEn = (mEn & 'hFF00) | busWrData;
        if (a == 9) mEn = (mEn & 'h00FF) | (int'(busWrData) << 8);
        if (a == 12) mMask = (mMask & 'hFF00) | busWrData;
        if (a == 13) mMask = (mMask & 'h00FF) | (int'(busWrData) << 8);
        if (a >= 32) begin
          int c;
          c = (a - 32) / 2;
          if (a % 2 == 0) begin sRise[c] = busWrData; if (!oldMask[c]) aRise[c] = busWrData; end
          else begin sFall[c] = busWrData; if (!oldMask[c]) aFall[c] = busWrData; end
        end
      end
    end
  end

  function automatic logic [15:0] modelOut();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin
      bit w;
      if (aRise[i] <= aFall[i]) w = (mSc >= aRise[i]) && (mSc < aFall[i]);
      else w = (mSc >= aRise[i]) || (mSc < aFall[i]);
      v[i] = mEn[i] && w;
    end
    return v;
  endfunction

  // cycle-by-cycle comparison against the model
  always @(negedge clk) if (rstN && !finished) begin
    testsRun++;
    if (pwmOut !== modelOut()) begin
      testsFailed++;
      $display("FAIL %s cycle compare: pwmOut=%h expected=%h", tag, pwmOut, modelOut());
    end
  end

  task automatic check(input string r, input int act, input int exp, input string what);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); busAddr = 6'(a); busWrData = 8'(d); busWrEn = 1;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic wrNow(input int a, input int d);
    busAddr = 6'(a); busWrData = 8'(d); busWrEn = 1;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic rdChk(input string r, input int a, input int exp);
    @(negedge clk); busAddr = 6'(a); #1;
    check(r, int'(busRdData), exp, $sformatf("read addr 0x%0h", a));
  endtask

  task automatic countHigh(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); hi += pwmOut[ch]; end
  endtask

  task automatic waitBoundary();
    do @(negedge clk); while (!(mPc == mPre && mSc == mPer));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tag = "R1";
    check("R1", int'(pwmOut), 0, "outputs after reset");
    rdChk("R1", 0, 0); rdChk("R1", 1, 255); rdChk("R1", 2, 0);
    rdChk("R1", 8, 0); rdChk("R1", 32, 0);

    // R6: period 0xFF, rise 0 fall 0xFF is low one step per period
    tag = "R6";
    wr(40, 0); wr(41, 255); wr(8, 'h10);
    repeat (2) @(negedge clk);
    countHigh(4, 256, hi);
    check("R6", hi, 255, "ch4 high cycles with period 0xFF");

    // R8/R11/R2: stage prescale 1, period 9
    tag = "R8";
    wr(0, 1); wr(1, 9);
    rdChk("R11", 0, 1); rdChk("R11", 1, 9);
    wr(2, 1);
    rdChk("R8", 2, 1);
    repeat (300) @(negedge clk);
    rdChk("R8", 2, 0);

    tag = "R4";
    wr(32, 2); wr(33, 5);
    wr(34, 7); wr(35, 3);
    wr(36, 0); wr(37, 10);
    wr(38, 4); wr(39, 4);
    wr(50, 1); wr(51, 6);
    wr(8, 'h0F); wr(9, 'h02);
    repeat (3) @(negedge clk);
    countHigh(0, 20, hi); check("R4", hi, 6, "ch0 rise 2 fall 5");
    countHigh(3, 20, hi); check("R4", hi, 0, "ch3 rise equals fall");
    countHigh(1, 20, hi); check("R5", hi, 12, "ch1 inverted rise 7 fall 3");
    countHigh(2, 20, hi); check("R6", hi, 20, "ch2 full high");
    countHigh(9, 20, hi); check("R2", hi, 10, "ch9 rise 1 fall 6 in 20-cycle period");

    tag = "R3";
    wr(9, 0);
    countHigh(9, 20, hi); check("R3", hi, 0, "ch9 disabled via upper byte");
    rdChk("R3", 9, 0);

    tag = "R7";
    wr(12, 'h01); wr(32, 6);
    countHigh(0, 40, hi); check("R7", hi, 12, "ch0 staged rise has no effect");
    rdChk("R11", 32, 6);
    wr(2, 1);
    repeat (30) @(negedge clk);
    rdChk("R8", 2, 0);
    countHigh(0, 20, hi); check("R8", hi, 18, "ch0 after transfer rise 6 fall 5");

    tag = "R9";
    wr(35, 5);
    countHigh(1, 20, hi); check("R9", hi, 16, "ch1 direct fall write");

    tag = "R10";
    wr(33, 8); wr(2, 1);
    waitBoundary();
    wrNow(32, 1);
    countHigh(0, 20, hi); check("R10", hi, 4, "staged write at transfer not carried");
    rdChk("R10", 2, 0);
    wr(2, 1);
    waitBoundary();
    wrNow(2, 1);
    rdChk("R10", 2, 1);
    repeat (25) @(negedge clk);
    rdChk("R10", 2, 0);
    countHigh(0, 20, hi); check("R10", hi, 14, "second transfer carries rise 1");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule